// File: doc/BRIEF.md
# Shared Multi-Lane PHY Bring-Up Sequencer

This block controls a serial PHY whose lanes share one reset and one PLL. Each lane can ask for the PHY to be switched on or released. The block keeps a count of how many lanes are using the PHY.

Only the enable that takes the count from zero to one does the full bring-up:

1. Release the PHY reset.
2. Take every lane out of idle.
3. Through an indirect configuration port:
   - wait for the PLL to lock;
   - fix the PLL at its stable rate;
   - switch on the reference-clock output;
   - wait for that clock to be ungated;
   - wait for the PLL to lock again.

Later enables only add to the count. A disable puts its own lane into idle and lowers the count. The disable that brings the count to zero puts the PHY back into reset.

Every accepted request ends with a one-cycle `done` pulse and an error code. Each poll is a single register read. Reads are separated by a programmable wait, and each polling phase allows a bounded number of attempts. If a poll runs out of attempts, the sequence aborts: the PHY is reset, all lanes go idle and the use count returns to zero. A disable that arrives while the count is already zero is reported as unpaired and changes nothing.

Top module: `phy_bringup_seq`

## Requirements
- R1: After reset, `phy_rst` is 1, every `lane_idle` bit is 1, and `busy` and `done` are 0.
- R2: An enable accepted while the use count is zero drops `phy_rst` at once. All `lane_idle` bits clear exactly one cycle after `phy_rst` falls.
- R3: In the first phase the block reads address 0x10 until bit 1 (PLL locked) is 1. It then writes data 0x8 to address 0x10, then data 0x8 to address 0x12. These are the only configuration writes.
- R4: Next it reads address 0x12 until bit 2 (clock gated) is 0. Then it reads address 0x10 until bit 1 is 1 again. After that it pulses `done` with `err_code` 0.
- R5: Each polling phase allows at most MAX_TRIES reads, and the attempt budget is reloaded at the start of every phase. If a phase runs out, `err_code` is 1, 2 or 3 for the first, second or third phase, `phy_rst` returns to 1, all `lane_idle` bits become 1 and the use count becomes zero.
- R6: Within one phase, consecutive `cfg_rd` strobes are exactly `wait_cycles`+2 cycles apart. `cfg_rd` and `cfg_wr` are never high together.
- R7: An enable while the count is nonzero adds one to the count. It pulses `done` in the next cycle with `err_code` 0, makes no configuration access and leaves `lane_idle` unchanged.
- R8: A disable while the count is nonzero sets only its own lane's idle bit and subtracts one from the count. If the count reaches zero, `phy_rst` goes to 1.
- R9: A disable while the count is zero pulses `done` with `err_code` 4 and leaves `lane_idle`, `phy_rst` and the count unchanged.
- R10: `busy` is high while a bring-up runs. Requests arriving while `busy` is high are dropped. `done` is high for one cycle, in the cycle that `busy` falls.
- R11: When several requests arrive in the same cycle, only one is taken. Any enable wins over any disable, and the lowest lane index wins within a kind. The rest are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_req | input | LANES | Per-lane single-cycle enable requests |
| dis_req | input | LANES | Per-lane single-cycle disable requests |
| wait_cycles | input | WAIT_W | Wait between poll reads (number of cycles) |
| cfg_rdata | input | 4 | Read data of the configuration port for `cfg_addr` |
| busy | output | 1 | Bring-up in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 3 | 0 ok, 1 lock timeout, 2 ungate timeout, 3 relock timeout, 4 unpaired disable |
| lane_idle | output | LANES | Per-lane idle controls |
| phy_rst | output | 1 | PHY reset, high = held in reset |
| cfg_addr | output | 6 | Configuration register address |
| cfg_wdata | output | 4 | Configuration write data |
| cfg_wr | output | 1 | Configuration write strobe |
| cfg_rd | output | 1 | Strobe marking the cycle in which `cfg_rdata` is sampled |

## Verification
The bench builds the block with four lanes, MAX_TRIES set to 5, a 4-bit wait width and a wait of 3 cycles. With these values, a timeout in each of the three phases takes only a few dozen cycles, so all three can be forced. A behavioural PHY model is used, with per-phase delays that can be set to "never".

The small attempt budget makes it possible to count the reads in a failing phase and see the reload between phases. It also makes it possible to measure the exact spacing between reads. The four lanes are enough to exercise the enable and disable priority, and to drive the reference count up to three and back down to zero.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RELEASE, ST_WAIT, ST_CHECK, ST_WR1, ST_WR2
  } seq_state_t;

  typedef enum logic [1:0] {
    PH_LOCK, PH_GATE, PH_RELOCK
  } phase_t;

  typedef enum logic [2:0] {
    ERR_NONE     = 3'd0,
    ERR_LOCK     = 3'd1,
    ERR_GATE     = 3'd2,
    ERR_RELOCK   = 3'd3,
    ERR_UNPAIRED = 3'd4
  } err_t;

  // Configuration space: addresses and bit positions the PHY decodes
  localparam logic [5:0] REG_PLL    = 6'h10;
  localparam logic [5:0] REG_CLK    = 6'h12;
  localparam int         LOCK_BIT   = 1;
  localparam int         GATE_BIT   = 2;
  localparam logic [3:0] RATE_FIX   = 4'h8;
  localparam logic [3:0] REFOUT_ON  = 4'h8;

endpackage

// File: rtl/seq_req_arb.sv
module seq_req_arb #(
  parameter int LANES = 4,
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [LANES-1:0] en_req,
  input  logic [LANES-1:0] dis_req,
  output logic             req_valid,
  output logic             req_en,
  output logic [IDX_W-1:0] req_lane
);

  // Enable beats disable; lowest lane index wins within a kind.
  always_comb begin
    req_valid = 1'b0;
    req_en    = 1'b0;
    req_lane  = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (dis_req[i]) begin
        req_valid = 1'b1;
        req_lane  = IDX_W'(i);
      end
    end
    for (int i = LANES - 1; i >= 0; i--) begin
      if (en_req[i]) begin
        req_valid = 1'b1;
        req_en    = 1'b1;
        req_lane  = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/seq_use_cnt.sv
module seq_use_cnt #(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic inc,
  input  logic dec,
  input  logic clr,
  output logic is_zero,
  output logic is_one
);

  logic [CNT_W-1:0] users;

  always_ff @(posedge clk) begin
    if (rst || clr) users <= '0;
    else if (inc)   users <= users + 1'b1;
    else if (dec)   users <= users - 1'b1;
  end

  assign is_zero = (users == '0);
  assign is_one  = (users == CNT_W'(1));

  // R9
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    dec |-> !is_zero);

endmodule

// File: rtl/seq_poll_timer.sv
module seq_poll_timer #(
  parameter int WAIT_W    = 8,
  parameter int MAX_TRIES = 100,
  localparam int TRY_W    = $clog2(MAX_TRIES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              retry,
  input  logic [WAIT_W-1:0] wait_cycles,
  output logic              wait_zero,
  output logic              last_try
);

  logic [WAIT_W-1:0] wcnt;
  logic [TRY_W-1:0]  tries;

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt  <= '0;
      tries <= '0;
    end else if (start) begin
      wcnt  <= wait_cycles;
      tries <= TRY_W'(MAX_TRIES);
    end else if (retry) begin
      wcnt  <= wait_cycles;
      tries <= tries - 1'b1;
    end else if (wcnt != '0) begin
      wcnt <= wcnt - 1'b1;
    end
  end

  assign wait_zero = (wcnt == '0);
  assign last_try  = (tries == TRY_W'(1));

  // R5
  retry_bound_chk: assert property (@(posedge clk) disable iff (rst)
    retry |-> (tries > TRY_W'(1)));

endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
  import phy_seq_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int MAX_TRIES = 100,
  parameter int WAIT_W    = 8,
  parameter int CNT_W     = 4,
  localparam int IDX_W    = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LANES-1:0]  en_req,
  input  logic [LANES-1:0]  dis_req,
  input  logic [WAIT_W-1:0] wait_cycles,
  input  logic [3:0]        cfg_rdata,
  output logic              busy,
  output logic              done,
  output logic [2:0]        err_code,
  output logic [LANES-1:0]  lane_idle,
  output logic              phy_rst,
  output logic [5:0]        cfg_addr,
  output logic [3:0]        cfg_wdata,
  output logic              cfg_wr,
  output logic              cfg_rd
);

  seq_state_t       state;
  phase_t           phase;
  logic             req_valid, req_en;
  logic [IDX_W-1:0] req_lane;
  logic             cnt_zero, cnt_one, cnt_inc, cnt_dec, cnt_clr;
  logic             wait_zero, last_try, tmr_start, tmr_retry;
  logic             accept, cond_met, fail;

  seq_req_arb #(.LANES(LANES)) u_arb (
    .en_req(en_req), .dis_req(dis_req),
    .req_valid(req_valid), .req_en(req_en), .req_lane(req_lane)
  );

  seq_use_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .inc(cnt_inc), .dec(cnt_dec), .clr(cnt_clr),
    .is_zero(cnt_zero), .is_one(cnt_one)
  );

  seq_poll_timer #(.WAIT_W(WAIT_W), .MAX_TRIES(MAX_TRIES)) u_tmr (
    .clk(clk), .rst(rst), .start(tmr_start), .retry(tmr_retry),
    .wait_cycles(wait_cycles), .wait_zero(wait_zero), .last_try(last_try)
  );

  always_comb begin
    accept    = (state == ST_IDLE) && req_valid;
    cond_met  = (phase == PH_GATE) ? !cfg_rdata[GATE_BIT] : cfg_rdata[LOCK_BIT];
    tmr_start = (state == ST_RELEASE) || (state == ST_WR2) ||
                (state == ST_CHECK && cond_met && phase == PH_GATE);
    tmr_retry = (state == ST_CHECK) && !cond_met && !last_try;
    fail      = (state == ST_CHECK) && !cond_met && last_try;
    cnt_inc   = accept && req_en;
    cnt_dec   = accept && !req_en && !cnt_zero;
    cnt_clr   = fail;
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      phase     <= PH_LOCK;
      phy_rst   <= 1'b1;
      lane_idle <= '1;
      done      <= 1'b0;
      err_code  <= ERR_NONE;
      cfg_addr  <= REG_PLL;
      cfg_wdata <= '0;
      cfg_wr    <= 1'b0;
      cfg_rd    <= 1'b0;
    end else begin
      done   <= 1'b0;
      cfg_wr <= 1'b0;
      cfg_rd <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            if (req_en) begin
              if (cnt_zero) begin
                phy_rst <= 1'b0;
                state   <= ST_RELEASE;
              end else begin
                done     <= 1'b1;
                err_code <= ERR_NONE;
              end
            end else if (cnt_zero) begin
              done     <= 1'b1;
              err_code <= ERR_UNPAIRED;
            end else begin
              lane_idle[req_lane] <= 1'b1;
              if (cnt_one) phy_rst <= 1'b1;
              done     <= 1'b1;
              err_code <= ERR_NONE;
            end
          end
        end
        ST_RELEASE: begin
          lane_idle <= '0;
          phase     <= PH_LOCK;
          cfg_addr  <= REG_PLL;
          state     <= ST_WAIT;
        end
        ST_WAIT: begin
          if (wait_zero) begin
            cfg_rd <= 1'b1;
            state  <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (cond_met) begin
            case (phase)
              PH_LOCK: begin
                cfg_wr    <= 1'b1;
                cfg_addr  <= REG_PLL;
                cfg_wdata <= RATE_FIX;
                state     <= ST_WR1;
              end
              PH_GATE: begin
                phase    <= PH_RELOCK;
                cfg_addr <= REG_PLL;
                state    <= ST_WAIT;
              end
              default: begin
                done     <= 1'b1;
                err_code <= ERR_NONE;
                state    <= ST_IDLE;
              end
            endcase
          end else if (last_try) begin
            done      <= 1'b1;
            err_code  <= (phase == PH_LOCK) ? ERR_LOCK :
                         (phase == PH_GATE) ? ERR_GATE : ERR_RELOCK;
            phy_rst   <= 1'b1;
            lane_idle <= '1;
            state     <= ST_IDLE;
          end else begin
            state <= ST_WAIT;
          end
        end
        ST_WR1: begin
          cfg_wr    <= 1'b1;
          cfg_addr  <= REG_CLK;
          cfg_wdata <= REFOUT_ON;
          state     <= ST_WR2;
        end
        ST_WR2: begin
          phase <= PH_GATE;
          state <= ST_WAIT;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8
  rst_when_unused_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && cnt_zero) |-> phy_rst);

  // R2
  idle_after_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(phy_rst) |=> (lane_idle == '0));

  // R10
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R3
  write_in_seq_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |-> busy);

  // R6
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(cfg_rd && cfg_wr));

  // R9
  unpaired_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && err_code == ERR_UNPAIRED) |-> ($stable(lane_idle) && phy_rst));

endmodule

// File: tb/test_phy_bringup_seq.sv
module test_phy_bringup_seq;
  localparam int LANES = 4;
  localparam int TRIES = 5;
  localparam int WAIT_W = 4;
  localparam int WAITV = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst;
  logic [LANES-1:0] en_req, dis_req;
  logic [WAIT_W-1:0] wait_cycles;
  logic [3:0] cfg_rdata;
  logic busy, done, phy_rst, cfg_wr, cfg_rd;
  logic [2:0] err_code;
  logic [LANES-1:0] lane_idle;
  logic [5:0] cfg_addr;
  logic [3:0] cfg_wdata;

  phy_bringup_seq #(.LANES(LANES), .MAX_TRIES(TRIES), .WAIT_W(WAIT_W), .CNT_W(4))
    i_phy_bringup_seq (
      .clk(clk), .rst(rst), .en_req(en_req), .dis_req(dis_req),
      .wait_cycles(wait_cycles), .cfg_rdata(cfg_rdata), .busy(busy),
      .done(done), .err_code(err_code), .lane_idle(lane_idle),
      .phy_rst(phy_rst), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .cfg_wr(cfg_wr), .cfg_rd(cfg_rd));

  // PHY model: delays in cycles, negative means never
  int lock_d, gate_d, relock_d;
  int t_rel, t_test, t_scc;
  bit wt, ws;
  always @(posedge clk) begin
    if (phy_rst) begin
      t_rel <= 0; t_test <= 0; t_scc <= 0; wt <= 0; ws <= 0;
    end else begin
      t_rel <= t_rel + 1; t_test <= t_test + 1; t_scc <= t_scc + 1;
      if (cfg_wr && cfg_addr == 6'h10) begin wt <= 1; t_test <= 0; end
      if (cfg_wr && cfg_addr == 6'h12) begin ws <= 1; t_scc <= 0; end
    end
  end
  logic lock_bit, gate_bit;
  assign lock_bit = wt ? (relock_d >= 0 && t_test >= relock_d)
                       : (lock_d >= 0 && t_rel >= lock_d);
  assign gate_bit = !(ws && gate_d >= 0 && t_scc >= gate_d);
  assign cfg_rdata = (cfg_addr == 6'h10) ? {2'b00, lock_bit, 1'b0} :
                     (cfg_addr == 6'h12) ? {1'b0, gate_bit, 2'b00} : 4'h0;

  typedef struct {logic [2:0] err; logic [3:0] idle; logic rst; string req;} exp_done_t;
  typedef struct {logic [5:0] addr; logic [3:0] data;} exp_wr_t;
  exp_done_t done_q[$];
  exp_wr_t   wr_q[$];
  exp_done_t ed;
  exp_wr_t   ew;

  int checks = 0, fails = 0, cyc = 0;
  int cnt10 = 0, cnt12 = 0, last_rd = -1;
  bit gap_on = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (done) begin
        if (done_q.size() == 0) check(0, "R10", "unexpected done", 1, 0);
        else begin
          ed = done_q.pop_front();
          check(err_code == ed.err, ed.req, "err_code", err_code, ed.err);
          check(lane_idle == ed.idle, ed.req, "lane_idle", lane_idle, ed.idle);
          check(phy_rst == ed.rst, ed.req, "phy_rst", phy_rst, ed.rst);
        end
      end
      if (cfg_wr) begin
        if (wr_q.size() == 0) check(0, "R3", "unexpected write", cfg_addr, 0);
        else begin
          ew = wr_q.pop_front();
          check(cfg_addr == ew.addr && cfg_wdata == ew.data, "R3", "write",
                {cfg_addr, cfg_wdata}, {ew.addr, ew.data});
        end
        cnt10 = 0; cnt12 = 0;
      end
      if (cfg_rd) begin
        if (cfg_addr == 6'h10) cnt10++;
        else if (cfg_addr == 6'h12) cnt12++;
        if (gap_on && last_rd >= 0)
          check(cyc - last_rd == WAITV + 2, "R6", "read gap", cyc - last_rd, WAITV + 2);
        last_rd = cyc;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; fails++;
      $display("FAIL R10 watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic pulse(input logic [3:0] en, input logic [3:0] dis);
    @(negedge clk); en_req = en; dis_req = dis;
    @(negedge clk); en_req = '0; dis_req = '0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic exp_done(input logic [2:0] e, input logic [3:0] idle,
                          input logic r, input string req);
    exp_done_t x;
    x.err = e; x.idle = idle; x.rst = r; x.req = req;
    done_q.push_back(x);
  endtask

  task automatic exp_writes();
    exp_wr_t a;
    a.addr = 6'h10; a.data = 4'h8; wr_q.push_back(a);
    a.addr = 6'h12; a.data = 4'h8; wr_q.push_back(a);
  endtask

  initial begin
    rst = 1; en_req = '0; dis_req = '0; wait_cycles = WAIT_W'(WAITV);
    lock_d = 12; gate_d = 6; relock_d = 8;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check(phy_rst == 1, "R1", "phy_rst", phy_rst, 1);
    check(lane_idle == 4'hF, "R1", "lane_idle", lane_idle, 4'hF);
    check(busy == 0 && done == 0, "R1", "busy/done", {busy, done}, 0);

    // R9 unpaired disable at count zero
    exp_done(3'd4, 4'hF, 1, "R9");
    pulse(4'b0000, 4'b0100); wait_done();

    // R2 R3 R4 first enable, with R10 requests while busy
    exp_writes();
    exp_done(3'd0, 4'h0, 0, "R4");
    @(negedge clk); en_req = 4'b0001;
    @(negedge clk); en_req = '0;
    check(phy_rst == 0 && lane_idle == 4'hF, "R2", "release before unidle",
          {phy_rst, lane_idle}, 5'h0F);
    @(negedge clk);
    check(lane_idle == 4'h0, "R2", "lanes unidled", lane_idle, 0);
    check(busy == 1, "R10", "busy during bring-up", busy, 1);
    pulse(4'b0100, 4'b0010);  // R10: dropped
    wait_done();
    check(busy == 0, "R10", "busy after done", busy, 0);

    // R7 later enable only counts
    exp_done(3'd0, 4'h0, 0, "R7");
    pulse(4'b0010, 4'b0000); wait_done();

    // R11 enable beats disable
    exp_done(3'd0, 4'h0, 0, "R11");
    pulse(4'b1000, 4'b0001); wait_done();
    // R11 lowest disable wins (lane 1), lane 3 dropped
    exp_done(3'd0, 4'b0010, 0, "R11");
    pulse(4'b0000, 4'b1010); wait_done();
    // R8 per-lane idle and last-user reset
    exp_done(3'd0, 4'b0011, 0, "R8");
    pulse(4'b0000, 4'b0001); wait_done();
    exp_done(3'd0, 4'b1011, 1, "R8");
    pulse(4'b0000, 4'b1000); wait_done();
    exp_done(3'd4, 4'b1011, 1, "R9");
    pulse(4'b0000, 4'b0001); wait_done();

    // R5 lock timeout, R6 spacing
    lock_d = -1; cnt10 = 0; last_rd = -1; gap_on = 1;
    exp_done(3'd1, 4'hF, 1, "R5");
    pulse(4'b0100, 4'b0000); wait_done();
    gap_on = 0;
    check(cnt10 == TRIES, "R5", "lock reads", cnt10, TRIES);

    // R5 ungate timeout
    lock_d = 0; gate_d = -1;
    exp_writes();
    exp_done(3'd2, 4'hF, 1, "R5");
    pulse(4'b0001, 4'b0000); wait_done();
    check(cnt12 == TRIES, "R5", "ungate reads", cnt12, TRIES);

    // R5 relock timeout
    gate_d = 0; relock_d = -1;
    exp_writes();
    exp_done(3'd3, 4'hF, 1, "R5");
    pulse(4'b0001, 4'b0000); wait_done();
    check(cnt10 == TRIES, "R5", "relock reads", cnt10, TRIES);

    // recovery: full bring-up then release
    lock_d = 12; gate_d = 6; relock_d = 8;
    exp_writes();
    exp_done(3'd0, 4'h0, 0, "R4");
    pulse(4'b1000, 4'b0000); wait_done();
    exp_done(3'd0, 4'b0001, 1, "R8");
    pulse(4'b0000, 4'b0001); wait_done();

    repeat (3) @(negedge clk);
    check(done_q.size() == 0, "R10", "pending dones", done_q.size(), 0);
    check(wr_q.size() == 0, "R3", "pending writes", wr_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule